// File: doc/BRIEF.md
# Peripheral Bus Decode Bridge

This block sits between a 16-bit asynchronous CPU slave port, selected by one active-low chip select, and a peripheral bus. The peripheral bus carries a dual UART, an Ethernet controller and an audio synthesizer. The chip-select window is split into address sub-windows. From the window that is hit and the transfer direction, the bridge produces peripheral chip selects and one of three kinds of strobe: I/O, memory or DMA. Accesses to the low register window raise a flag for a separate register file, which is not part of this block.

The UART and the synthesizer use an 8-bit data bus and a 3-bit register address. The bridge chooses one byte lane of the CPU bus from the byte enables. On a write it drives that lane onto the narrow bus. On a read it returns the narrow bus data on that same lane. The Ethernet controller's DMA request goes straight through to the CPU. Reads of the DMA sub-window are acknowledged only while that request is high.

All inputs are sampled on the rising clock edge, and every output comes from a register with a synchronous active-high reset. Each output therefore shows the inputs seen at the previous rising edge.

Top module: `pbus_bridge`

## Requirements
- R1: While `rst` is high, and after it, until the first access: all active-low strobes, acknowledge and chip selects are 1, and `synth_cs`, `per_aen`, `reg_sel`, `per_wdata_oe`, `cpu_rdata_oe` and `cpu_dmareq` are 0.
- R2: Every output is registered, so it shows the inputs sampled at the previous rising edge. When `cpu_cs_n` was sampled high, no strobe, acknowledge, chip select or `reg_sel` is active.
- R3: The windows are offsets of `cpu_addr`:
  - registers: 0x0_0000–0x0_FFFF, which raises `reg_sel`
  - UART A: 0x1_0000–0x1_000F
  - UART B: 0x1_0010–0x1_001F
  - Ethernet I/O: 0x2_0000–0x2_0FFF
  - Ethernet memory: 0x2_1000–0x2_1FFF
  - Ethernet DMA: 0x2_2000–0x2_2FFF
  - synthesizer: 0x3_0000–0x3_000F

  Any other address asserts nothing.
- R4: A read is `cpu_rw_n`=1 with `cpu_oe_n`=0. A write is `cpu_rw_n`=0 with at least one byte enable low. In the UART, Ethernet I/O and synthesizer windows, a read drives `per_ior_n` low and a write drives `per_iow_n` low.
- R5: In the Ethernet memory window, a read drives `per_memr_n` low and a write drives `per_memw_n` low. No I/O strobe is driven there.
- R6: A hit in a window selects its peripheral for any direction. UART A selects `uart_a_cs_n`=0 and UART B selects `uart_b_cs_n`=0. The Ethernet I/O and memory windows select `enet_cs_n`=0, and the synthesizer window selects `synth_cs`=1. At most one select or `reg_sel` is active at a time.
- R7: A read of the DMA window while `enet_dmareq` is 1 drives `enet_dmack_n`=0, `per_ior_n`=0 and `per_aen`=1. A DMA-window read without the request, or a DMA-window write, asserts none of these, and `enet_cs_n` stays 1.
- R8: `cpu_dmareq` equals `enet_dmareq` delayed by one clock.
- R9: `per_addr` equals `cpu_addr[3:1]`.
- R10: The byte lane is the low lane (bits 7:0) when `cpu_be_n[0]` is 0, and the high lane (bits 15:8) otherwise. `per_wdata` carries the selected lane of `cpu_wdata`. `per_wdata_oe` is 1 only for a write in a UART or synthesizer window.
- R11: `cpu_rdata_oe` is 1 only for a read in a UART or synthesizer window. Then `cpu_rdata` carries `per_rdata` on the selected lane and zeros on the other lane. Otherwise `cpu_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 26 | CPU address offset within the chip-select window |
| cpu_wdata | input | 16 | CPU write data |
| cpu_cs_n | input | 1 | CPU chip select, active low |
| cpu_be_n | input | 2 | Byte enables, active low; bit 0 is data 7:0 |
| cpu_oe_n | input | 1 | CPU output enable, active low |
| cpu_rw_n | input | 1 | 1 = read, 0 = write |
| cpu_rdata | output | 16 | Read data returned to the CPU |
| cpu_rdata_oe | output | 1 | CPU data bus drive enable |
| cpu_dmareq | output | 1 | DMA request to the CPU |
| per_addr | output | 3 | Peripheral register address |
| per_wdata | output | 8 | Narrow bus write data |
| per_wdata_oe | output | 1 | Narrow bus drive enable |
| per_rdata | input | 8 | Narrow bus read data |
| per_ior_n | output | 1 | I/O read strobe, active low |
| per_iow_n | output | 1 | I/O write strobe, active low |
| per_memr_n | output | 1 | Memory read strobe, active low |
| per_memw_n | output | 1 | Memory write strobe, active low |
| per_aen | output | 1 | DMA address enable |
| enet_dmareq | input | 1 | DMA request from the Ethernet controller |
| enet_dmack_n | output | 1 | DMA acknowledge, active low |
| enet_cs_n | output | 1 | Ethernet chip select, active low |
| uart_a_cs_n | output | 1 | UART port A select, active low |
| uart_b_cs_n | output | 1 | UART port B select, active low |
| synth_cs | output | 1 | Synthesizer select, active high |
| reg_sel | output | 1 | Register window access flag |

## Verification
Random addresses are drawn mostly from inside each window. Some are picked just past a window edge, which separates off-by-one decode faults from correct boundaries. Fully random addresses show that unmapped space stays quiet.

Direction, output enable, byte enables and the DMA request are varied on their own. This separates:
- I/O strobes from memory strobes;
- gated DMA acknowledges from ungated ones;
- low-lane steering from high-lane steering.

Directed cases cover four corners: a write with no byte enable active, a DMA read with the request low, a DMA write with the request high, and a hit in a window while the chip select is high.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  typedef enum logic [2:0] {
    WIN_NONE,
    WIN_REGS,
    WIN_UART_A,
    WIN_UART_B,
    WIN_ENET_IO,
    WIN_ENET_MEM,
    WIN_ENET_DMA,
    WIN_SYNTH
  } pbus_win_e;

  // Active-high internal control bundle; inverted at the pins where needed.
  typedef struct packed {
    logic ior;
    logic iow;
    logic memr;
    logic memw;
    logic dmack;
    logic aen;
    logic enet_cs;
    logic uart_a_cs;
    logic uart_b_cs;
    logic synth_cs;
    logic reg_sel;
    logic narrow_wr;
    logic narrow_rd;
  } pbus_ctl_t;

endpackage

// File: rtl/pbus_win_decode.sv
module pbus_win_decode
  import pbus_pkg::*;
#(
  parameter int ADDR_W        = 26,
  parameter int REG_BASE      = 32'h0_0000,
  parameter int REG_SPAN_LG   = 16,
  parameter int UART_A_BASE   = 32'h1_0000,
  parameter int UART_B_BASE   = 32'h1_0010,
  parameter int UART_SPAN_LG  = 4,
  parameter int ENET_IO_BASE  = 32'h2_0000,
  parameter int ENET_MEM_BASE = 32'h2_1000,
  parameter int ENET_DMA_BASE = 32'h2_2000,
  parameter int ENET_SPAN_LG  = 12,
  parameter int SYNTH_BASE    = 32'h3_0000,
  parameter int SYNTH_SPAN_LG = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output pbus_win_e         win
);

  localparam logic [ADDR_W-1:0] ONE       = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] REG_MASK  = ~((ONE << REG_SPAN_LG) - ONE);
  localparam logic [ADDR_W-1:0] UART_MASK = ~((ONE << UART_SPAN_LG) - ONE);
  localparam logic [ADDR_W-1:0] ENET_MASK = ~((ONE << ENET_SPAN_LG) - ONE);
  localparam logic [ADDR_W-1:0] SYN_MASK  = ~((ONE << SYNTH_SPAN_LG) - ONE);

  logic hit_reg, hit_ua, hit_ub, hit_eio, hit_emem, hit_edma, hit_syn;

  assign hit_reg  = (addr & REG_MASK)  == ADDR_W'(REG_BASE);
  assign hit_ua   = (addr & UART_MASK) == ADDR_W'(UART_A_BASE);
  assign hit_ub   = (addr & UART_MASK) == ADDR_W'(UART_B_BASE);
  assign hit_eio  = (addr & ENET_MASK) == ADDR_W'(ENET_IO_BASE);
  assign hit_emem = (addr & ENET_MASK) == ADDR_W'(ENET_MEM_BASE);
  assign hit_edma = (addr & ENET_MASK) == ADDR_W'(ENET_DMA_BASE);
  assign hit_syn  = (addr & SYN_MASK)  == ADDR_W'(SYNTH_BASE);

  always_comb begin
    win = WIN_NONE;
    if      (hit_reg)  win = WIN_REGS;
    else if (hit_ua)   win = WIN_UART_A;
    else if (hit_ub)   win = WIN_UART_B;
    else if (hit_eio)  win = WIN_ENET_IO;
    else if (hit_emem) win = WIN_ENET_MEM;
    else if (hit_edma) win = WIN_ENET_DMA;
    else if (hit_syn)  win = WIN_SYNTH;
  end

endmodule

// File: rtl/pbus_strobe_gen.sv
module pbus_strobe_gen
  import pbus_pkg::*;
(
  input  logic      sel,
  input  pbus_win_e win,
  input  logic      rd,
  input  logic      wr,
  input  logic      dma_req,
  output pbus_ctl_t ctl
);

  always_comb begin
    ctl = '0;
    if (sel) begin
      unique case (win)
        WIN_REGS: ctl.reg_sel = 1'b1;
        WIN_UART_A: begin
          ctl.uart_a_cs = 1'b1;
          ctl.ior       = rd;
          ctl.iow       = wr;
          ctl.narrow_rd = rd;
          ctl.narrow_wr = wr;
        end
        WIN_UART_B: begin
          ctl.uart_b_cs = 1'b1;
          ctl.ior       = rd;
          ctl.iow       = wr;
          ctl.narrow_rd = rd;
          ctl.narrow_wr = wr;
        end
        WIN_SYNTH: begin
          ctl.synth_cs  = 1'b1;
          ctl.ior       = rd;
          ctl.iow       = wr;
          ctl.narrow_rd = rd;
          ctl.narrow_wr = wr;
        end
        WIN_ENET_IO: begin
          ctl.enet_cs = 1'b1;
          ctl.ior     = rd;
          ctl.iow     = wr;
        end
        WIN_ENET_MEM: begin
          ctl.enet_cs = 1'b1;
          ctl.memr    = rd;
          ctl.memw    = wr;
        end
        WIN_ENET_DMA: begin
          ctl.dmack = rd & dma_req;
          ctl.ior   = rd & dma_req;
          ctl.aen   = rd & dma_req;
        end
        default: ctl = '0;
      endcase
    end
  end

endmodule

// File: rtl/pbus_lane_steer.sv
module pbus_lane_steer #(
  parameter int DATA_W  = 16,
  parameter int PDATA_W = 8
) (
  input  logic [DATA_W/PDATA_W-1:0] be_n,
  input  logic [DATA_W-1:0]         cpu_wdata,
  input  logic [PDATA_W-1:0]        per_rdata,
  output logic [PDATA_W-1:0]        per_wdata,
  output logic [DATA_W-1:0]         cpu_rdata
);

  localparam int NUM_LANES = DATA_W / PDATA_W;
  localparam int LANE_W    = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;

  logic [LANE_W-1:0] lane;

  // Lowest active byte enable wins; with none active the top lane is used.
  always_comb begin
    lane = LANE_W'(NUM_LANES - 1);
    for (int i = NUM_LANES - 1; i >= 0; i--) begin
      if (!be_n[i]) lane = LANE_W'(i);
    end
  end

  assign per_wdata = cpu_wdata[lane*PDATA_W +: PDATA_W];

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_rlane
    assign cpu_rdata[g*PDATA_W +: PDATA_W] =
      (lane == LANE_W'(g)) ? per_rdata : '0;
  end

endmodule

// File: rtl/pbus_bridge.sv
module pbus_bridge
  import pbus_pkg::*;
#(
  parameter int ADDR_W  = 26,
  parameter int DATA_W  = 16,
  parameter int PDATA_W = 8,
  parameter int PADDR_W = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          cpu_addr,
  input  logic [DATA_W-1:0]          cpu_wdata,
  input  logic                       cpu_cs_n,
  input  logic [DATA_W/PDATA_W-1:0]  cpu_be_n,
  input  logic                       cpu_oe_n,
  input  logic                       cpu_rw_n,
  output logic [DATA_W-1:0]          cpu_rdata,
  output logic                       cpu_rdata_oe,
  output logic                       cpu_dmareq,
  output logic [PADDR_W-1:0]         per_addr,
  output logic [PDATA_W-1:0]         per_wdata,
  output logic                       per_wdata_oe,
  input  logic [PDATA_W-1:0]         per_rdata,
  output logic                       per_ior_n,
  output logic                       per_iow_n,
  output logic                       per_memr_n,
  output logic                       per_memw_n,
  output logic                       per_aen,
  input  logic                       enet_dmareq,
  output logic                       enet_dmack_n,
  output logic                       enet_cs_n,
  output logic                       uart_a_cs_n,
  output logic                       uart_b_cs_n,
  output logic                       synth_cs,
  output logic                       reg_sel
);

  localparam int NUM_LANES = DATA_W / PDATA_W;

  pbus_win_e          win;
  pbus_ctl_t          ctl_d, ctl_q;
  logic               rd, wr;
  logic [PDATA_W-1:0] pw_d;
  logic [DATA_W-1:0]  rlane_d;
  logic [DATA_W-1:0]  rdata_q;
  logic [PADDR_W-1:0] paddr_q;
  logic [PDATA_W-1:0] pw_q;
  logic               req_q;

  assign rd = cpu_rw_n & ~cpu_oe_n;
  assign wr = ~cpu_rw_n & (cpu_be_n != {NUM_LANES{1'b1}});

  pbus_win_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (cpu_addr),
    .win  (win)
  );

  pbus_strobe_gen u_stb (
    .sel     (~cpu_cs_n),
    .win     (win),
    .rd      (rd),
    .wr      (wr),
    .dma_req (enet_dmareq),
    .ctl     (ctl_d)
  );

  pbus_lane_steer #(.DATA_W(DATA_W), .PDATA_W(PDATA_W)) u_lane (
    .be_n      (cpu_be_n),
    .cpu_wdata (cpu_wdata),
    .per_rdata (per_rdata),
    .per_wdata (pw_d),
    .cpu_rdata (rlane_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q   <= '0;
      rdata_q <= '0;
      paddr_q <= '0;
      pw_q    <= '0;
      req_q   <= 1'b0;
    end else begin
      ctl_q   <= ctl_d;
      rdata_q <= ctl_d.narrow_rd ? rlane_d : '0;
      paddr_q <= cpu_addr[PADDR_W:1];
      pw_q    <= pw_d;
      req_q   <= enet_dmareq;
    end
  end

  assign cpu_rdata    = rdata_q;
  assign cpu_rdata_oe = ctl_q.narrow_rd;
  assign cpu_dmareq   = req_q;
  assign per_addr     = paddr_q;
  assign per_wdata    = pw_q;
  assign per_wdata_oe = ctl_q.narrow_wr;
  assign per_ior_n    = ~ctl_q.ior;
  assign per_iow_n    = ~ctl_q.iow;
  assign per_memr_n   = ~ctl_q.memr;
  assign per_memw_n   = ~ctl_q.memw;
  assign per_aen      = ctl_q.aen;
  assign enet_dmack_n = ~ctl_q.dmack;
  assign enet_cs_n    = ~ctl_q.enet_cs;
  assign uart_a_cs_n  = ~ctl_q.uart_a_cs;
  assign uart_b_cs_n  = ~ctl_q.uart_b_cs;
  assign synth_cs     = ctl_q.synth_cs;
  assign reg_sel      = ctl_q.reg_sel;

endmodule

// File: rtl/pbus_bridge_chk.sv
module pbus_bridge_chk (
  input logic clk,
  input logic rst,
  input logic cpu_cs_n,
  input logic cpu_oe_n,
  input logic cpu_rw_n,
  input logic enet_dmareq,
  input logic cpu_rdata_oe,
  input logic cpu_dmareq,
  input logic per_ior_n,
  input logic per_iow_n,
  input logic per_memr_n,
  input logic per_memw_n,
  input logic per_aen,
  input logic enet_dmack_n,
  input logic enet_cs_n,
  input logic uart_a_cs_n,
  input logic uart_b_cs_n,
  input logic synth_cs,
  input logic reg_sel
);

  logic past_ok;
  always_ff @(posedge clk) past_ok <= rst ? 1'b0 : 1'b1;

  assert_idle_deselected_R2: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(cpu_cs_n)) |->
      (per_ior_n && per_iow_n && per_memr_n && per_memw_n && enet_dmack_n &&
       !per_aen && enet_cs_n && uart_a_cs_n && uart_b_cs_n && !synth_cs && !reg_sel));

  assert_no_rw_clash_R4: assert property (@(posedge clk) disable iff (rst)
    !(!per_ior_n && !per_iow_n));

  assert_mem_targets_enet_R5: assert property (@(posedge clk) disable iff (rst)
    (!per_memr_n || !per_memw_n) |-> (!enet_cs_n && per_ior_n && per_iow_n));

  assert_single_select_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({!uart_a_cs_n, !uart_b_cs_n, !enet_cs_n, synth_cs, reg_sel}));

  assert_dmack_gated_R7: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !enet_dmack_n) |-> ($past(enet_dmareq) && !per_ior_n && per_aen && enet_cs_n));

  assert_req_forward_R8: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (cpu_dmareq == $past(enet_dmareq)));

  assert_rdata_drive_R11: assert property (@(posedge clk) disable iff (rst)
    (past_ok && cpu_rdata_oe) |-> $past(!cpu_cs_n && cpu_rw_n && !cpu_oe_n));

endmodule

bind pbus_bridge pbus_bridge_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .cpu_cs_n     (cpu_cs_n),
  .cpu_oe_n     (cpu_oe_n),
  .cpu_rw_n     (cpu_rw_n),
  .enet_dmareq  (enet_dmareq),
  .cpu_rdata_oe (cpu_rdata_oe),
  .cpu_dmareq   (cpu_dmareq),
  .per_ior_n    (per_ior_n),
  .per_iow_n    (per_iow_n),
  .per_memr_n   (per_memr_n),
  .per_memw_n   (per_memw_n),
  .per_aen      (per_aen),
  .enet_dmack_n (enet_dmack_n),
  .enet_cs_n    (enet_cs_n),
  .uart_a_cs_n  (uart_a_cs_n),
  .uart_b_cs_n  (uart_b_cs_n),
  .synth_cs     (synth_cs),
  .reg_sel      (reg_sel)
);

// File: tb/pbus_bridge_test.sv
module pbus_bridge_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [25:0] cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic        cpu_cs_n = 1'b1;
  logic [1:0]  cpu_be_n = 2'b11;
  logic        cpu_oe_n = 1'b1;
  logic        cpu_rw_n = 1'b1;
  logic [7:0]  per_rdata = '0;
  logic        enet_dmareq = 1'b0;
  logic [15:0] cpu_rdata;
  logic        cpu_rdata_oe, cpu_dmareq, per_wdata_oe;
  logic [2:0]  per_addr;
  logic [7:0]  per_wdata;
  logic        per_ior_n, per_iow_n, per_memr_n, per_memw_n, per_aen;
  logic        enet_dmack_n, enet_cs_n, uart_a_cs_n, uart_b_cs_n, synth_cs, reg_sel;

  int  n_run = 0;
  int  n_fail = 0;
  bit  done = 0;

  always #10 clk = ~clk;

  pbus_bridge uut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_cs_n(cpu_cs_n), .cpu_be_n(cpu_be_n), .cpu_oe_n(cpu_oe_n),
    .cpu_rw_n(cpu_rw_n), .cpu_rdata(cpu_rdata), .cpu_rdata_oe(cpu_rdata_oe),
    .cpu_dmareq(cpu_dmareq), .per_addr(per_addr), .per_wdata(per_wdata),
    .per_wdata_oe(per_wdata_oe), .per_rdata(per_rdata), .per_ior_n(per_ior_n),
    .per_iow_n(per_iow_n), .per_memr_n(per_memr_n), .per_memw_n(per_memw_n),
    .per_aen(per_aen), .enet_dmareq(enet_dmareq), .enet_dmack_n(enet_dmack_n),
    .enet_cs_n(enet_cs_n), .uart_a_cs_n(uart_a_cs_n), .uart_b_cs_n(uart_b_cs_n),
    .synth_cs(synth_cs), .reg_sel(reg_sel)
  );

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // 0 none, 1 regs, 2 uart A, 3 uart B, 4 enet io, 5 enet mem, 6 dma, 7 synth
  function automatic int win_of(logic [25:0] a);
    if (a[25:16] == 10'h000)  return 1;
    if (a[25:4] == 22'h1000)  return 2;
    if (a[25:4] == 22'h1001)  return 3;
    if (a[25:12] == 14'h20)   return 4;
    if (a[25:12] == 14'h21)   return 5;
    if (a[25:12] == 14'h22)   return 6;
    if (a[25:4] == 22'h3000)  return 7;
    return 0;
  endfunction

  task automatic access(logic [25:0] a, logic [15:0] wd, logic cs_n, logic [1:0] be_n,
                        logic oe_n, logic rw_n, logic req, logic [7:0] prd);
    int w;
    logic s, rd, wr, narrow, hi;
    logic e_ior, e_iow, e_memr, e_memw, e_aen, e_dack, e_pwoe, e_roe;
    logic [15:0] e_rdata;
    string stag;
    cpu_addr = a; cpu_wdata = wd; cpu_cs_n = cs_n; cpu_be_n = be_n;
    cpu_oe_n = oe_n; cpu_rw_n = rw_n; enet_dmareq = req; per_rdata = prd;
    @(posedge clk);
    @(negedge clk);
    w  = win_of(a);
    s  = ~cs_n;
    rd = rw_n & ~oe_n;
    wr = ~rw_n & (be_n != 2'b11);
    narrow = (w == 2) || (w == 3) || (w == 7);
    hi = be_n[0];
    e_ior  = s & ((rd & (narrow || w == 4)) | (rd & req & (w == 6)));
    e_iow  = s & wr & (narrow || w == 4);
    e_memr = s & rd & (w == 5);
    e_memw = s & wr & (w == 5);
    e_aen  = s & rd & req & (w == 6);
    e_dack = e_aen;
    e_pwoe = s & wr & narrow;
    e_roe  = s & rd & narrow;
    e_rdata = !e_roe ? 16'h0 : (hi ? {prd, 8'h00} : {8'h00, prd});
    if (!s)          stag = "R2";
    else if (w == 5) stag = "R5";
    else if (w == 6) stag = "R7";
    else if (narrow || w == 4) stag = "R4";
    else             stag = "R3";
    chk(stag, "strobes {ior,iow,memr,memw,aen,dmack}",
        16'({~per_ior_n, ~per_iow_n, ~per_memr_n, ~per_memw_n, per_aen, ~enet_dmack_n}),
        16'({e_ior, e_iow, e_memr, e_memw, e_aen, e_dack}));
    chk(s ? "R6" : "R2", "selects {ua,ub,enet,synth,reg}",
        16'({~uart_a_cs_n, ~uart_b_cs_n, ~enet_cs_n, synth_cs, reg_sel}),
        16'({s & (w == 2), s & (w == 3), s & (w == 4 || w == 5), s & (w == 7), s & (w == 1)}));
    chk("R9", "per_addr", 16'(per_addr), 16'(a[3:1]));
    chk("R10", "per_wdata/oe", {7'h0, per_wdata_oe, per_wdata},
        {7'h0, e_pwoe, (hi ? wd[15:8] : wd[7:0])});
    chk("R11", "cpu_rdata", cpu_rdata, e_rdata);
    chk("R11", "cpu_rdata_oe", 16'(cpu_rdata_oe), 16'(e_roe));
    chk("R8", "cpu_dmareq", 16'(cpu_dmareq), 16'(req));
  endtask

  function automatic logic [25:0] pick_addr();
    int k;
    k = int'($urandom % 10);
    case (k)
      0: return 26'h0_0000 | 26'($urandom % 32'h1_0000);
      1: return 26'h1_0000 | 26'($urandom % 16);
      2: return 26'h1_0010 | 26'($urandom % 16);
      3: return 26'h2_0000 | 26'($urandom % 32'h1000);
      4: return 26'h2_1000 | 26'($urandom % 32'h1000);
      5: return 26'h2_2000 | 26'($urandom % 32'h1000);
      6: return 26'h3_0000 | 26'($urandom % 16);
      7: begin
        case ($urandom % 4)
          0: return 26'h1_0020;
          1: return 26'h2_3000;
          2: return 26'h3_0010;
          default: return 26'h0_FFFF + 26'd1 + 26'h3_0000;
        endcase
      end
      default: return 26'($urandom);
    endcase
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "inactive-low outputs",
        16'({per_ior_n, per_iow_n, per_memr_n, per_memw_n, enet_dmack_n,
             enet_cs_n, uart_a_cs_n, uart_b_cs_n}), 16'hFF);
    chk("R1", "active-high outputs",
        16'({synth_cs, per_aen, reg_sel, per_wdata_oe, cpu_rdata_oe, cpu_dmareq}), 16'h0);
    rst = 1'b0;
    // Directed corner cases
    access(26'h1_0004, 16'hA55A, 1'b1, 2'b10, 1'b0, 1'b1, 1'b0, 8'h3C); // deselected, R2
    access(26'h1_0006, 16'h1234, 1'b0, 2'b10, 1'b1, 1'b0, 1'b0, 8'h00); // UART A write low lane
    access(26'h1_0018, 16'hBEEF, 1'b0, 2'b01, 1'b1, 1'b0, 1'b0, 8'h00); // UART B write high lane
    access(26'h3_000E, 16'h0000, 1'b0, 2'b01, 1'b0, 1'b1, 1'b0, 8'hC3); // synth read high lane
    access(26'h1_0002, 16'h5566, 1'b0, 2'b11, 1'b1, 1'b0, 1'b0, 8'h00); // write no byte enable
    access(26'h2_1000, 16'h0000, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 8'h00); // memory read
    access(26'h2_2000, 16'h0000, 1'b0, 2'b00, 1'b0, 1'b1, 1'b1, 8'h00); // DMA read with req
    access(26'h2_2FFE, 16'h0000, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 8'h00); // DMA read no req
    access(26'h2_2002, 16'h9999, 1'b0, 2'b00, 1'b1, 1'b0, 1'b1, 8'h00); // DMA write with req
    access(26'h2_3000, 16'h0000, 1'b0, 2'b00, 1'b0, 1'b1, 1'b1, 8'h00); // just past DMA
    access(26'h0_0016, 16'h0000, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 8'h00); // register window
    // Random mix
    for (int i = 0; i < 600; i++) begin
      access(pick_addr(), 16'($urandom), ($urandom % 5) == 0, 2'($urandom),
             1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom));
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule